// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address strobe of a multiplexed processor bus and puts the memory side of the chip into a low-power state when the bus goes quiet. The strobe is brought into the domain of a free-running input clock through a two-flop synchronizer. An edge detector finds each strobe transition. A saturating idle counter counts input-clock cycles since the last transition. When the counter reaches its limit, the power-down flag rises.

While the flag is high, the block cuts the processor bus off from the memories and forces the flash, EEPROM and SRAM selects inactive. It turns off the output enables of the data port and the peripheral port. It freezes the processor I/O group at the level it had when power-down began. Logic-array outputs keep passing through untouched. The address outputs are left as they are, since any value is allowed there.

The flag clears in three ways: strobe activity resumes, the chip select returns low, or reset is applied. A chip select driven high forces power-down at once. A management enable bit switches the whole unit on and off. A separate clock-block bit gates the logic-array clock but never the counter clock.

Top module: `bus_idle_pdn`

## Requirements
- R1: With `enable_i` low, `pdn_o` is low whatever the strobe or chip select do. The counter is held at zero. After `enable_i` rises with the strobe idle and the chip selected, `pdn_o` rises at the 15th clock edge.
- R2: A strobe transition applied just after clock edge k clears the idle counter at edge k+3: two synchronizer flops, then one compare stage. From then on the counter advances by one per edge while the strobe is quiet.
- R3: With the 4-bit default configuration, `pdn_o` rises once the counter reaches 15, which is edge k+18 after a strobe transition. The counter saturates at 15 and does not wrap, so `pdn_o` stays high until a wake condition occurs.
- R4: Strobe activity wakes the block. After a transition just after edge k, `pdn_o` is low from edge k+3. While transitions keep coming less than 18 edges apart, `pdn_o` stays low.
- R5: When `csel_n_i` goes high just after edge k, `pdn_o` is high from edge k+2 on, while enabled. The counter is held clear while the select is high. When `csel_n_i` returns low just after edge j, `pdn_o` is low from edge j+2 and rises again at edge j+17 if the strobe stays idle.
- R6: Asserting `rst_n` low drops `pdn_o` at once, without a clock. Release is synchronized by two flops.
- R7: While `pdn_o` is high, `bus_en_o` is 0 and all three bits of `mem_sel_o` are 0. Bit 0 is flash, bit 1 is EEPROM, bit 2 is SRAM. While `pdn_o` is low, `mem_sel_o` equals `mem_sel_i` and `bus_en_o` is 1.
- R8: While `pdn_o` is high, `mcu_io_o` holds the value `mcu_io_i` had at the last edge before power-down. `pld_o` follows `pld_i` at all times. After wake, `mcu_io_o` follows `mcu_io_i` again.
- R9: While `pdn_o` is high, `data_oe_o` and `periph_oe_o` are all zero, which places those ports in tri-state. Otherwise they equal their inputs.
- R10: `clk_block_i` high drives `pld_clk_en_o` low but leaves the idle timer running, so the R3 timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock for the idle timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Unit enable from the management register |
| clk_block_i | input | 1 | Blocks the common clock from the logic arrays |
| strobe_i | input | 1 | Asynchronous address strobe |
| csel_n_i | input | 1 | Active-low chip select, asynchronous |
| mem_sel_i | input | 3 | Requested selects: bit 0 flash, bit 1 EEPROM, bit 2 SRAM |
| data_oe_i | input | 8 | Data-port output enables |
| periph_oe_i | input | 8 | Peripheral-port output enables |
| mcu_io_i | input | 8 | Processor I/O output levels |
| pld_i | input | 8 | Logic-array output levels |
| pdn_o | output | 1 | Power-down flag |
| bus_en_o | output | 1 | Processor bus connected to memories |
| mem_sel_o | output | 3 | Gated memory selects |
| data_oe_o | output | 8 | Gated data-port output enables |
| periph_oe_o | output | 8 | Gated peripheral-port output enables |
| mcu_io_o | output | 8 | Processor I/O levels, frozen in power-down |
| pld_o | output | 8 | Logic-array output levels |
| pld_clk_en_o | output | 1 | Enable for the logic-array clock |

## Verification
The assertions check several things on every cycle. A detected edge clears the counter, and each quiet cycle steps it by one. The counter saturates at its limit and stays at zero while disabled. Power-down always implies closed selects, disabled port enables and a frozen processor I/O group.

Only the bench scenarios can show the absolute latencies. These are the three-edge wake after a strobe toggle, the eighteen-edge entry, the two-edge chip-select response and the re-entry at seventeen edges. The bench also shows that the clock-block bit leaves that timing untouched and that reset clears the flag with no clock.

// File: rtl/bus_idle_pdn_pkg.sv
package bus_idle_pdn_pkg;
  localparam int unsigned MEM_SEL_W  = 3;
  localparam int unsigned SEL_FLASH  = 0;
  localparam int unsigned SEL_EEPROM = 1;
  localparam int unsigned SEL_SRAM   = 2;
  typedef logic [MEM_SEL_W-1:0] mem_sel_t;
endpackage

// File: rtl/bip_sync.sv
module bip_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign edge_o[g]  = sync_q[g] ^ prev_q[g];
    assign level_o[g] = sync_q[g];
  end
endmodule

// File: rtl/bip_idle_timer.sv
module bip_idle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic activity_i,
  input  logic hold_clr_i,
  output logic full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr;

  always_comb begin
    clr   = !en_i || activity_i || hold_clr_i;
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == CNT_MAX);

  // R2: a detected strobe edge empties the counter
  p_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> (cnt_q == '0));
  // R2: quiet enabled cycles advance by exactly one
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !activity_i && !hold_clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: saturation, no wrap
  p_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && en_i && !activity_i) |=> (cnt_q == CNT_MAX));
  // R1: disabled unit keeps the counter empty
  p_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/bip_port_gate.sv
module bip_port_gate
  import bus_idle_pdn_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned MCU_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_i,
  input  mem_sel_t          mem_sel_i,
  input  logic [DATA_W-1:0] data_oe_i,
  input  logic [PER_W-1:0]  periph_oe_i,
  input  logic [MCU_W-1:0]  mcu_io_i,
  output logic              bus_en_o,
  output mem_sel_t          mem_sel_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic [PER_W-1:0]  periph_oe_o,
  output logic [MCU_W-1:0]  mcu_io_o
);
  logic [MCU_W-1:0] hold_q, hold_d;
  logic             hold_en;

  assign hold_en = !pdn_i;

  always_comb begin
    hold_d = hold_q;
    if (hold_en) hold_d = mcu_io_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  always_comb begin
    bus_en_o    = !pdn_i;
    mem_sel_o   = pdn_i ? '0 : mem_sel_i;
    data_oe_o   = pdn_i ? '0 : data_oe_i;
    periph_oe_o = pdn_i ? '0 : periph_oe_i;
    mcu_io_o    = pdn_i ? hold_q : mcu_io_i;
  end

  // R8: processor I/O frozen across consecutive power-down cycles
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_i && $past(pdn_i)) |-> $stable(mcu_io_o));
endmodule

// File: rtl/bus_idle_pdn.sv
module bus_idle_pdn
  import bus_idle_pdn_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned MCU_W  = 8,
  parameter int unsigned PLD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              clk_block_i,
  input  logic              strobe_i,
  input  logic              csel_n_i,
  input  logic [2:0]        mem_sel_i,
  input  logic [DATA_W-1:0] data_oe_i,
  input  logic [PER_W-1:0]  periph_oe_i,
  input  logic [MCU_W-1:0]  mcu_io_i,
  input  logic [PLD_W-1:0]  pld_i,
  output logic              pdn_o,
  output logic              bus_en_o,
  output logic [2:0]        mem_sel_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic [PER_W-1:0]  periph_oe_o,
  output logic [MCU_W-1:0]  mcu_io_o,
  output logic [PLD_W-1:0]  pld_o,
  output logic              pld_clk_en_o
);
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned IDX_STB = 0;
  localparam int unsigned IDX_CS  = 1;

  logic              rst_meta_q, rst_q;
  logic [SYNC_N-1:0] sync_lvl, sync_edge;
  logic              idle_full, cs_high, pdn;

  // reset: asynchronous assert, synchronized release
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  bip_sync #(.N(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .async_i ({csel_n_i, strobe_i}),
    .level_o (sync_lvl),
    .edge_o  (sync_edge)
  );

  assign cs_high = sync_lvl[IDX_CS];

  bip_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_q),
    .en_i       (enable_i),
    .activity_i (sync_edge[IDX_STB]),
    .hold_clr_i (cs_high),
    .full_o     (idle_full)
  );

  assign pdn = enable_i && (idle_full || cs_high) && rst_n;

  bip_port_gate #(.DATA_W(DATA_W), .PER_W(PER_W), .MCU_W(MCU_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_q),
    .pdn_i       (pdn),
    .mem_sel_i   (mem_sel_i),
    .data_oe_i   (data_oe_i),
    .periph_oe_i (periph_oe_i),
    .mcu_io_i    (mcu_io_i),
    .bus_en_o    (bus_en_o),
    .mem_sel_o   (mem_sel_o),
    .data_oe_o   (data_oe_o),
    .periph_oe_o (periph_oe_o),
    .mcu_io_o    (mcu_io_o)
  );

  assign pdn_o        = pdn;
  assign pld_o        = pld_i;
  assign pld_clk_en_o = !clk_block_i;

  // R7: no memory select and no bus path during power-down
  p_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_q)
    pdn_o |-> (mem_sel_o == '0 && !bus_en_o));
  // R9: data and peripheral drivers released during power-down
  p_tri_r9: assert property (@(posedge clk_i) disable iff (!rst_q)
    pdn_o |-> (data_oe_o == '0 && periph_oe_o == '0));
  // R8: logic-array outputs never gated
  p_pld_r8: assert property (@(posedge clk_i) disable iff (!rst_q)
    pld_o == pld_i);
endmodule

// File: tb/bus_idle_pdn_test.sv
module bus_idle_pdn_test;
  logic       clk_i = 1'b0;
  logic       rst_n, enable_i, clk_block_i, strobe_i, csel_n_i;
  logic [2:0] mem_sel_i;
  logic [7:0] data_oe_i, periph_oe_i, mcu_io_i, pld_i;
  logic       pdn_o, bus_en_o, pld_clk_en_o;
  logic [2:0] mem_sel_o;
  logic [7:0] data_oe_o, periph_oe_o, mcu_io_o, pld_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  bus_idle_pdn uut (
    .clk_i(clk_i), .rst_n(rst_n), .enable_i(enable_i), .clk_block_i(clk_block_i),
    .strobe_i(strobe_i), .csel_n_i(csel_n_i), .mem_sel_i(mem_sel_i),
    .data_oe_i(data_oe_i), .periph_oe_i(periph_oe_i), .mcu_io_i(mcu_io_i),
    .pld_i(pld_i), .pdn_o(pdn_o), .bus_en_o(bus_en_o), .mem_sel_o(mem_sel_o),
    .data_oe_o(data_oe_o), .periph_oe_o(periph_oe_o), .mcu_io_o(mcu_io_o),
    .pld_o(pld_o), .pld_clk_en_o(pld_clk_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk_gate(input logic exp_pdn);
    chk("R7 bus_en", {31'd0, bus_en_o}, {31'd0, !exp_pdn});
    chk("R7 mem_sel", {29'd0, mem_sel_o}, exp_pdn ? 32'd0 : {29'd0, mem_sel_i});
    chk("R9 data_oe", {24'd0, data_oe_o}, exp_pdn ? 32'd0 : {24'd0, data_oe_i});
    chk("R9 periph_oe", {24'd0, periph_oe_o}, exp_pdn ? 32'd0 : {24'd0, periph_oe_i});
    chk("R8 pld", {24'd0, pld_o}, {24'd0, pld_i});
  endtask

  // toggle strobe just after an edge, then follow 20 edges
  task automatic toggle_sweep(input string req, input bit was_pdn);
    strobe_i = ~strobe_i;
    for (int n = 1; n <= 20; n++) begin
      tick();
      chk(req, {31'd0, pdn_o}, {31'd0, (n >= 18) || (n < 3 && was_pdn)});
      chk_gate((n >= 18) || (n < 3 && was_pdn));
    end
  endtask

  initial begin
    rst_n = 1'b0; enable_i = 1'b1; clk_block_i = 1'b0; strobe_i = 1'b0; csel_n_i = 1'b0;
    mem_sel_i = 3'b101; data_oe_i = 8'hF0; periph_oe_i = 8'h0F; mcu_io_i = 8'h11; pld_i = 8'h22;
    #1;
    chk("R6 reset pdn", {31'd0, pdn_o}, 32'd0);
    chk_gate(1'b0);
    tick(); tick();
    rst_n = 1'b1;
    for (int i = 0; i < 22; i++) tick();
    chk("R3 idle after reset", {31'd0, pdn_o}, 32'd1);

    // R2 R3 R4: exact entry and wake latency, repeated
    for (int t = 0; t < 3; t++) begin
      mem_sel_i = 3'(t + 1); data_oe_i = 8'(t * 37); periph_oe_i = 8'(t * 53 + 1);
      toggle_sweep("R3 R4 toggle sweep", 1'b1);
    end

    // R4: frequent activity keeps the unit awake
    for (int k = 0; k < 8; k++) begin
      strobe_i = ~strobe_i;
      for (int n = 1; n <= 10; n++) begin
        tick();
        if (!(k == 0 && n < 3)) chk("R4 active bus", {31'd0, pdn_o}, 32'd0);
      end
    end

    // R8: processor I/O frozen at entry value
    mcu_io_i = 8'hA5;
    for (int n = 0; n < 20; n++) tick();
    chk("R8 entered", {31'd0, pdn_o}, 32'd1);
    mcu_io_i = 8'h3C; pld_i = 8'h77;
    tick();
    chk("R8 mcu held", {24'd0, mcu_io_o}, 32'hA5);
    chk("R8 pld passes", {24'd0, pld_o}, 32'h77);
    strobe_i = ~strobe_i;
    tick(); tick(); tick();
    chk("R8 mcu follows after wake", {24'd0, mcu_io_o}, 32'h3C);

    // R5: chip select
    csel_n_i = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      tick();
      chk("R5 deselect forces", {31'd0, pdn_o}, {31'd0, n >= 2});
    end
    for (int n = 0; n < 20; n++) tick();
    chk("R5 held by deselect", {31'd0, pdn_o}, 32'd1);
    csel_n_i = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      tick();
      chk("R5 select wake and re-entry", {31'd0, pdn_o}, {31'd0, (n < 2) || (n >= 17)});
    end

    // R1: disable
    enable_i = 1'b0;
    #1;
    chk("R1 disable drops", {31'd0, pdn_o}, 32'd0);
    csel_n_i = 1'b1;
    for (int n = 0; n < 20; n++) begin
      tick();
      chk("R1 disabled never powers down", {31'd0, pdn_o}, 32'd0);
    end
    csel_n_i = 1'b0;
    tick(); tick(); tick();
    enable_i = 1'b1;
    for (int n = 1; n <= 16; n++) begin
      tick();
      chk("R1 enable timing", {31'd0, pdn_o}, {31'd0, n >= 15});
    end

    // R10: clock block leaves the timer alone
    clk_block_i = 1'b1;
    #1;
    chk("R10 pld clock blocked", {31'd0, pld_clk_en_o}, 32'd0);
    toggle_sweep("R10 timer still runs", 1'b1);
    clk_block_i = 1'b0;
    #1;
    chk("R10 pld clock back", {31'd0, pld_clk_en_o}, 32'd1);

    // R6: reset wakes without a clock
    chk("R6 pre", {31'd0, pdn_o}, 32'd1);
    @(negedge clk_i);
    rst_n = 1'b0;
    #1;
    chk("R6 async wake", {31'd0, pdn_o}, 32'd0);
    chk_gate(1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule